// File: doc/BRIEF.md
# Two-Channel Triggered Packet DMA Controller

This block copies words from one address range to another through a one-word holding buffer inside the controller. The two channels always work as a pair. Channel 1 is the read side. It supplies the source base address, the transfer count and the packet size. Channel 2 is the write side and supplies the destination base address. For every word, the engine issues a read at the channel 1 pointer and then a write of the same data at the channel 2 pointer. Both accesses go through a single word-wide request/acknowledge memory port.

Software programs the registers and then sets the enable bit of both channels. After that, each trigger moves exactly one packet. A trigger can be a software trigger bit in either channel's control word, or a hardware event. For channel 1 the hardware event is chosen by an external 3-bit select. For channel 2 it is the second UART's transmit-empty or receive-full event. Triggers that arrive while a packet is still running are counted and served afterwards. When the last packet has been written, both enables drop, both done flags set, and an interrupt pulse is issued.

Top module: `pkt_dma`

## Requirements
- R1: After reset all six registers read 0, no memory request is raised and the interrupt output is low.
- R2: The count register (address 4) holds the number of packets minus one. Once that many packets plus one have moved, the transfer stops and further triggers move nothing.
- R3: The packet register (address 5, bits [7:0]) holds words per packet minus one. With 0, each trigger moves one word; with 2, it moves three.
- R4: Each word is a read at the source pointer followed by a write of the returned data at the destination pointer. A request holds its address, direction and data steady until acknowledged.
- R5: Control bit 3 set makes that channel's pointer start at its base register (source: address 2, destination: address 3) and step by one per word. Bit 3 clear keeps that channel's address fixed at its base.
- R6: Control bit 0 is the channel enable. A trigger is accepted only while both channels are enabled; one arriving earlier is dropped, not held.
- R7: Control bit 18 set on either channel, meaning the buffer lives outside the controller, blocks all triggers. Clearing it restores normal operation.
- R8: With channel 1 control bit 2 set, the select input value k in 1..6 makes a rising edge on hardware line k-1 a trigger. Other lines are ignored, select values 0 and 7 choose no line, and a held-high line counts once.
- R9: With channel 2 control bit 2 set, the UART mode input at 1 makes a rising edge of transmit-empty a trigger. At 0, a rising edge of receive-full is the trigger. The other event is ignored.
- R10: Writing 1 to control bit 1 (lane 0) of either channel issues a software trigger. The bit always reads 0.
- R11: On completion both enable bits clear, both done bits (bit 8) set and the interrupt pulses for exactly one cycle. Writing enable 1 clears that channel's done bit.
- R12: Triggers arriving while a packet runs are counted, up to 7, and each starts its own packet afterwards.
- R13: Control writes change only the byte lanes whose strobe is set (lane 0 = bits 7:0, lane 2 = bits 23:16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0/1 control ch1/ch2, 2/3 base ch1/ch2, 4 count, 5 packet |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ch1_trig_sel | input | 3 | Channel 1 hardware source select from external configuration |
| hw_trig | input | 6 | Hardware event lines for channel 1, including first-UART events |
| u2_tx_empty | input | 1 | Second UART transmit buffer empty |
| u2_rx_full | input | 1 | Second UART receive buffer full |
| u2_tx_mode | input | 1 | 1: second UART triggers on transmit-empty, 0: on receive-full |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a backlog of triggers. Several have to land while one packet is still waiting on a slow memory, and the backlog must also outlast the final packet. The bench stretches the memory latency to eight cycles and fires bursts of back-to-back software triggers. It then counts every write and checks that the queued triggers each moved one packet. Triggers left over after the count ran out must move nothing.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

    localparam int WORD_W = 32;

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_SW   = 1;
    localparam int CB_HWEN = 2;
    localparam int CB_STEP = 3;
    localparam int CB_DONE = 8;
    localparam int CB_EXT  = 18;

    typedef enum logic [2:0] {
        RA_CTL1  = 3'd0,
        RA_CTL2  = 3'd1,
        RA_BASE1 = 3'd2,
        RA_BASE2 = 3'd3,
        RA_COUNT = 3'd4,
        RA_PKT   = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic ext;
        logic done;
        logic step;
        logic hwen;
        logic en;
    } ctl_t;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_READ,
        XS_WRITE
    } xfer_state_e;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [3:0]        be
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_word(input ctl_t c);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[CB_EN]   = c.en;
        w[CB_HWEN] = c.hwen;
        w[CB_STEP] = c.step;
        w[CB_DONE] = c.done;
        w[CB_EXT]  = c.ext;
        return w;
    endfunction

endpackage

// File: rtl/pkt_dma_regs.sv
module pkt_dma_regs
    import pkt_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PKT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fin,
    output logic [1:0]        en_o,
    output logic [1:0]        hwen_o,
    output logic [1:0]        step_o,
    output logic [1:0]        ext_o,
    output logic [1:0]        sw_o,
    output logic [ADDR_W-1:0] base1_o,
    output logic [ADDR_W-1:0] base2_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [PKT_W-1:0]  pkt_o
);

    logic [WORD_W-1:0] ctl_rd [2];

    for (genvar c = 0; c < 2; c++) begin : g_ctl
        ctl_t cq;
        logic swq;
        logic hit;

        assign hit = reg_we && (reg_addr == 3'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cq  <= '0;
                swq <= 1'b0;
            end else begin
                swq <= hit && reg_be[0] && reg_wdata[CB_SW];
                if (hit && reg_be[0]) begin
                    cq.en   <= reg_wdata[CB_EN];
                    cq.hwen <= reg_wdata[CB_HWEN];
                    cq.step <= reg_wdata[CB_STEP];
                    if (reg_wdata[CB_EN]) cq.done <= 1'b0;
                end
                if (hit && reg_be[2]) begin
                    cq.ext <= reg_wdata[CB_EXT];
                end
                if (fin) begin
                    cq.en   <= 1'b0;
                    cq.done <= 1'b1;
                end
            end
        end

        assign en_o[c]   = cq.en;
        assign hwen_o[c] = cq.hwen;
        assign step_o[c] = cq.step;
        assign ext_o[c]  = cq.ext;
        assign sw_o[c]   = swq;
        assign ctl_rd[c] = ctl_word(cq);

        // R13: a write that skips lane 0 leaves the enable alone
        p_lane_keep_r13: assert property (@(posedge clk) disable iff (rst)
            (hit && !reg_be[0] && !fin) |=> $stable(cq.en));
    end

    logic [ADDR_W-1:0] base1_q, base2_q;
    logic [CNT_W-1:0]  count_q;
    logic [PKT_W-1:0]  pkt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base1_q <= '0;
            base2_q <= '0;
            count_q <= '0;
            pkt_q   <= '0;
        end else if (reg_we) begin
            case (reg_idx_e'(reg_addr))
                RA_BASE1: base1_q <= ADDR_W'(lane_merge(WORD_W'(base1_q), reg_wdata, reg_be));
                RA_BASE2: base2_q <= ADDR_W'(lane_merge(WORD_W'(base2_q), reg_wdata, reg_be));
                RA_COUNT: count_q <= CNT_W'(lane_merge(WORD_W'(count_q), reg_wdata, reg_be));
                RA_PKT:   pkt_q   <= PKT_W'(lane_merge(WORD_W'(pkt_q), reg_wdata, reg_be));
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            RA_CTL1:  reg_rdata = ctl_rd[0];
            RA_CTL2:  reg_rdata = ctl_rd[1];
            RA_BASE1: reg_rdata = WORD_W'(base1_q);
            RA_BASE2: reg_rdata = WORD_W'(base2_q);
            RA_COUNT: reg_rdata = WORD_W'(count_q);
            RA_PKT:   reg_rdata = WORD_W'(pkt_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign base1_o = base1_q;
    assign base2_o = base2_q;
    assign count_o = count_q;
    assign pkt_o   = pkt_q;

    // R11: completion disarms both channels and flags done
    p_fin_disarm_r11: assert property (@(posedge clk) disable iff (rst)
        fin |=> (en_o == 2'b00) && ctl_rd[0][CB_DONE] && ctl_rd[1][CB_DONE]);

endmodule

// File: rtl/pkt_dma_trig.sv
module pkt_dma_trig #(
    parameter int N_SRC  = 6,
    parameter int SEL_W  = 3,
    parameter int PEND_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] hw_trig,
    input  logic [SEL_W-1:0] sel,
    input  logic             u2_tx_empty,
    input  logic             u2_rx_full,
    input  logic             u2_tx_mode,
    input  logic [1:0]       hwen,
    input  logic [1:0]       sw,
    input  logic             armed,
    input  logic             take,
    input  logic             flush,
    output logic             pending
);

    logic [N_SRC-1:0]  hw_q;
    logic              tx_q, rx_q;
    logic [N_SRC-1:0]  hw_rise;
    logic              ch1_rise, ch2_rise, fire;
    logic [PEND_W-1:0] cnt;

    assign hw_rise = hw_trig & ~hw_q;

    always_comb begin
        ch1_rise = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i + 1)) ch1_rise = hw_rise[i];
        end
    end

    assign ch2_rise = u2_tx_mode ? (u2_tx_empty && !tx_q) : (u2_rx_full && !rx_q);
    assign fire     = armed && ((|sw) || (hwen[0] && ch1_rise) || (hwen[1] && ch2_rise));

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q <= '0;
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            hw_q <= hw_trig;
            tx_q <= u2_tx_empty;
            rx_q <= u2_rx_full;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush || !armed) begin
            cnt <= '0;
        end else begin
            case ({fire, take})
                2'b10:   if (cnt != '1) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    assign pending = (cnt != '0);

    // R12: the engine only starts a packet against a counted trigger
    p_take_backed_r12: assert property (@(posedge clk) disable iff (rst)
        take |-> cnt != '0);

endmodule

// File: rtl/pkt_dma_xfer.sv
module pkt_dma_xfer
    import pkt_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PKT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic              pending,
    input  logic              step_src,
    input  logic              step_dst,
    input  logic [ADDR_W-1:0] base_src,
    input  logic [ADDR_W-1:0] base_dst,
    input  logic [CNT_W-1:0]  count,
    input  logic [PKT_W-1:0]  pkt,
    output logic              take,
    output logic              fin,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    xfer_state_e       state;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic [CNT_W-1:0]  pkts_left;
    logic [PKT_W-1:0]  words_left;
    logic [WORD_W-1:0] hold;
    logic              started;
    logic              fin_q;

    assign take = (state == XS_IDLE) && armed && pending && !fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= XS_IDLE;
            src_ptr    <= '0;
            dst_ptr    <= '0;
            pkts_left  <= '0;
            words_left <= '0;
            hold       <= '0;
            started    <= 1'b0;
            fin_q      <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state)
                XS_IDLE: begin
                    if (take) begin
                        state      <= XS_READ;
                        words_left <= pkt;
                        if (!started) begin
                            src_ptr   <= base_src;
                            dst_ptr   <= base_dst;
                            pkts_left <= count;
                            started   <= 1'b1;
                        end
                    end else if (!armed) begin
                        started <= 1'b0;
                    end
                end
                XS_READ: begin
                    if (mem_ack) begin
                        hold  <= mem_rdata;
                        state <= XS_WRITE;
                    end
                end
                XS_WRITE: begin
                    if (mem_ack) begin
                        if (step_src) src_ptr <= src_ptr + 1'b1;
                        if (step_dst) dst_ptr <= dst_ptr + 1'b1;
                        if (words_left == '0) begin
                            state <= XS_IDLE;
                            if (pkts_left == '0) begin
                                fin_q   <= 1'b1;
                                started <= 1'b0;
                            end else begin
                                pkts_left <= pkts_left - 1'b1;
                            end
                        end else begin
                            words_left <= words_left - 1'b1;
                            state      <= XS_READ;
                        end
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    assign mem_req   = (state != XS_IDLE);
    assign mem_we    = (state == XS_WRITE);
    assign mem_addr  = (state == XS_WRITE) ? dst_ptr : src_ptr;
    assign mem_wdata = hold;
    assign fin       = fin_q;

    // R4: an unacknowledged request stays put
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R4: a write only ever follows a completed read
    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(mem_ack && !mem_we));

    // R11: completion is a single-cycle pulse on a quiet port
    p_fin_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);
    p_fin_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        fin |-> !mem_req);

endmodule

// File: rtl/pkt_dma.sv
module pkt_dma
    import pkt_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PKT_W  = 8,
    parameter int N_SRC  = 6,
    parameter int SEL_W  = 3,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [SEL_W-1:0]  ch1_trig_sel,
    input  logic [N_SRC-1:0]  hw_trig,
    input  logic              u2_tx_empty,
    input  logic              u2_rx_full,
    input  logic              u2_tx_mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done_irq
);

    logic [1:0]        en, hwen, step, ext, sw;
    logic [ADDR_W-1:0] base1, base2;
    logic [CNT_W-1:0]  count;
    logic [PKT_W-1:0]  pkt;
    logic              armed, pending, take, fin;

    assign armed = (en == 2'b11) && (ext == 2'b00);

    pkt_dma_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_W(PKT_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fin(fin),
        .en_o(en), .hwen_o(hwen), .step_o(step), .ext_o(ext), .sw_o(sw),
        .base1_o(base1), .base2_o(base2), .count_o(count), .pkt_o(pkt)
    );

    pkt_dma_trig #(
        .N_SRC(N_SRC), .SEL_W(SEL_W), .PEND_W(PEND_W)
    ) u_trig (
        .clk(clk), .rst(rst),
        .hw_trig(hw_trig), .sel(ch1_trig_sel),
        .u2_tx_empty(u2_tx_empty), .u2_rx_full(u2_rx_full), .u2_tx_mode(u2_tx_mode),
        .hwen(hwen), .sw(sw), .armed(armed),
        .take(take), .flush(fin), .pending(pending)
    );

    pkt_dma_xfer #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PKT_W(PKT_W)
    ) u_xfer (
        .clk(clk), .rst(rst),
        .armed(armed), .pending(pending),
        .step_src(step[0]), .step_dst(step[1]),
        .base_src(base1), .base_dst(base2),
        .count(count), .pkt(pkt),
        .take(take), .fin(fin),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign done_irq = fin;

    // R6/R7: no packet may begin while the pair is not armed
    p_start_armed_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(armed));

endmodule

// File: tb/pkt_dma_test.sv
`timescale 1ns/1ps
module pkt_dma_test;

    localparam logic [31:0] EN   = 32'h1;
    localparam logic [31:0] SW   = 32'h2;
    localparam logic [31:0] HWEN = 32'h4;
    localparam logic [31:0] STEP = 32'h8;
    localparam logic [31:0] DONE = 32'h100;
    localparam logic [31:0] EXT  = 32'h40000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  ch1_trig_sel = '0;
    logic [5:0]  hw_trig = '0;
    logic        u2_tx_empty = 1'b0;
    logic        u2_rx_full = 1'b0;
    logic        u2_tx_mode = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        done_irq;

    always #2.5 clk = ~clk;

    pkt_dma uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch1_trig_sel(ch1_trig_sel), .hw_trig(hw_trig),
        .u2_tx_empty(u2_tx_empty), .u2_rx_full(u2_rx_full), .u2_tx_mode(u2_tx_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done_irq(done_irq)
    );

    logic [31:0] mem [256];
    int lat = 1;
    int lat_cnt = 0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    int vecs = 0;
    int bad = 0;

    function automatic logic [31:0] pat(input int i);
        return 32'hC0DE0000 ^ (i * 32'h00010203);
    endfunction

    // memory model and interrupt counter, active on the falling edge
    always @(negedge clk) begin
        if (done_irq) irq_cnt++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem[mem_addr[7:0]];
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_wr(input int target);
        int n = 0;
        while (wr_cnt < target && n < 3000) begin
            @(negedge clk);
            n++;
        end
        settle(40);
    endtask

    task automatic cfg(input int b1, input int b2, input int cnt, input int pk,
                       input logic [31:0] c1, input logic [31:0] c2);
        wr(3'd0, 4'hF, 32'h0);
        wr(3'd1, 4'hF, 32'h0);
        settle(2);
        wr(3'd2, 4'hF, 32'(b1));
        wr(3'd3, 4'hF, 32'(b2));
        wr(3'd4, 4'hF, 32'(cnt));
        wr(3'd5, 4'hF, 32'(pk));
        wr(3'd0, 4'hF, c1);
        wr(3'd1, 4'hF, c2);
        settle(2);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", d, 32'h0);
        end
        chk("R1 no request", 32'(mem_req), 32'h0);
        chk("R1 irq low", 32'(done_irq), 32'h0);
    endtask

    task automatic t_single;
        int base, ib;
        logic [31:0] d;
        cfg(8, 64, 3, 0, EN | STEP, EN | STEP);
        base = wr_cnt; ib = irq_cnt;
        wr(3'd0, 4'hF, EN | STEP | SW);
        wait_wr(base + 1);
        chk("R3 one word per trigger", 32'(wr_cnt - base), 32'd1);
        chk("R4 copied word", mem[64], pat(8));
        wr(3'd1, 4'hF, EN | STEP | SW);   // R10 channel 2 software trigger
        wait_wr(base + 2);
        wr(3'd0, 4'hF, EN | STEP | SW);
        wait_wr(base + 3);
        wr(3'd1, 4'hF, EN | STEP | SW);
        wait_wr(base + 4);
        chk("R10 both channels trigger", 32'(wr_cnt - base), 32'd4);
        for (int i = 0; i < 4; i++) chk("R5 stepping copy", mem[64 + i], pat(8 + i));
        rd(3'd0, d);
        chk("R11 ch1 disarmed and done", d, DONE | STEP);
        rd(3'd1, d);
        chk("R11 ch2 disarmed and done", d, DONE | STEP);
        chk("R11 single irq pulse", 32'(irq_cnt - ib), 32'd1);
        wr(3'd0, 4'hF, STEP | SW);
        settle(40);
        chk("R2 nothing after count", 32'(wr_cnt - base), 32'd4);
        wr(3'd0, 4'hF, EN | STEP);
        rd(3'd0, d);
        chk("R11 enable clears done", d, EN | STEP);
    endtask

    task automatic t_packet;
        int base, ib;
        cfg(20, 100, 1, 2, EN | STEP, EN);
        base = wr_cnt; ib = irq_cnt;
        wr(3'd0, 4'hF, EN | STEP | SW);
        wait_wr(base + 3);
        chk("R3 three-word packet", 32'(wr_cnt - base), 32'd3);
        chk("R5 fixed destination", mem[100], pat(22));
        wr(3'd0, 4'hF, EN | STEP | SW);
        wait_wr(base + 6);
        chk("R2 two packets total", 32'(wr_cnt - base), 32'd6);
        chk("R5 fixed destination last", mem[100], pat(25));
        chk("R5 neighbour untouched", mem[101], pat(101));
        chk("R11 irq after packets", 32'(irq_cnt - ib), 32'd1);
    endtask

    task automatic pulse_hw(input logic [5:0] m, input int hold);
        @(negedge clk); hw_trig = m;
        settle(hold);
        hw_trig = '0;
        settle(40);
    endtask

    task automatic t_hwsel;
        int base;
        cfg(30, 140, 7, 0, EN | STEP | HWEN, EN | STEP);
        base = wr_cnt;
        ch1_trig_sel = 3'd3;
        pulse_hw(6'b000010, 2);
        chk("R8 unselected line ignored", 32'(wr_cnt - base), 32'd0);
        pulse_hw(6'b000100, 20);
        chk("R8 selected line, held high once", 32'(wr_cnt - base), 32'd1);
        chk("R8 copied word", mem[140], pat(30));
        ch1_trig_sel = 3'd0;
        pulse_hw(6'b111111, 2);
        chk("R8 select 0 chooses none", 32'(wr_cnt - base), 32'd1);
        ch1_trig_sel = 3'd7;
        pulse_hw(6'b111111, 2);
        chk("R8 select 7 chooses none", 32'(wr_cnt - base), 32'd1);
        ch1_trig_sel = 3'd6;
        pulse_hw(6'b100000, 2);
        chk("R8 top line selected", 32'(wr_cnt - base), 32'd2);
        ch1_trig_sel = 3'd0;
    endtask

    task automatic t_uart2;
        int base;
        cfg(40, 150, 7, 0, EN | STEP, EN | STEP | HWEN);
        base = wr_cnt;
        u2_tx_mode = 1'b1;
        @(negedge clk); u2_rx_full = 1'b1; settle(3); u2_rx_full = 1'b0; settle(40);
        chk("R9 rx-full ignored in tx mode", 32'(wr_cnt - base), 32'd0);
        @(negedge clk); u2_tx_empty = 1'b1; settle(3); u2_tx_empty = 1'b0; settle(40);
        chk("R9 tx-empty triggers", 32'(wr_cnt - base), 32'd1);
        u2_tx_mode = 1'b0;
        @(negedge clk); u2_tx_empty = 1'b1; settle(3); u2_tx_empty = 1'b0; settle(40);
        chk("R9 tx-empty ignored in rx mode", 32'(wr_cnt - base), 32'd1);
        @(negedge clk); u2_rx_full = 1'b1; settle(3); u2_rx_full = 1'b0; settle(40);
        chk("R9 rx-full triggers", 32'(wr_cnt - base), 32'd2);
        chk("R9 second word", mem[151], pat(41));
    endtask

    task automatic t_arm;
        int base;
        logic [31:0] d;
        cfg(50, 160, 3, 0, EN | STEP, STEP);
        base = wr_cnt;
        wr(3'd0, 4'hF, EN | STEP | SW);
        settle(40);
        wr(3'd1, 4'hF, EN | STEP);
        settle(40);
        chk("R6 early trigger dropped", 32'(wr_cnt - base), 32'd0);
        wr(3'd1, 4'b0100, EXT);
        rd(3'd1, d);
        chk("R13 lane 2 only", d, EXT | EN | STEP);
        wr(3'd0, 4'b1110, 32'h0);
        rd(3'd0, d);
        chk("R13 lane 0 kept", d, EN | STEP);
        wr(3'd0, 4'hF, EN | STEP | SW);
        settle(40);
        chk("R7 external buffer blocks", 32'(wr_cnt - base), 32'd0);
        wr(3'd1, 4'b0100, 32'h0);
        rd(3'd1, d);
        chk("R13 lane 2 cleared", d, EN | STEP);
        wr(3'd0, 4'hF, EN | STEP | SW);
        wait_wr(base + 1);
        chk("R7 cleared bit restores", 32'(wr_cnt - base), 32'd1);
        chk("R7 copied word", mem[160], pat(50));
    endtask

    task automatic t_pend;
        int base, ib;
        lat = 8;
        cfg(60, 170, 9, 0, EN | STEP, EN | STEP);
        base = wr_cnt; ib = irq_cnt;
        for (int i = 0; i < 3; i++) wr(3'd0, 4'hF, EN | STEP | SW);
        chk("R12 still busy after burst", 32'(wr_cnt - base) < 32'd3 ? 32'd1 : 32'd0, 32'd1);
        wait_wr(base + 3);
        settle(100);
        chk("R12 each queued trigger served", 32'(wr_cnt - base), 32'd3);
        for (int i = 0; i < 3; i++) chk("R12 queued data", mem[170 + i], pat(60 + i));
        for (int i = 0; i < 8; i++) wr(3'd1, 4'hF, EN | STEP | SW);
        wait_wr(base + 10);
        settle(200);
        chk("R2 excess triggers dropped", 32'(wr_cnt - base), 32'd10);
        chk("R11 one irq for backlog", 32'(irq_cnt - ib), 32'd1);
        chk("R12 last word", mem[179], pat(69));
        lat = 1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        settle(4);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_single();
        t_packet();
        t_hwsel();
        t_uart2();
        t_arm();
        t_pend();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule